// File: doc/BRIEF.md
# Interrupt Controller Command Decoder

This block is the byte-wide, two-address register front end of an eight-input priority interrupt controller. It turns host writes into configuration state and acknowledge actions. It also returns the selected register on each host read. A separate resolver block holds the request and in-service bits and picks the winning input. The resolver reads the outputs of this block: interrupt mask, vector base, rotation base, auto end-of-interrupt, rotate-on-auto-EOI, special nested, special mask and the register-select bit. Each output is a register.

The decoder has two write paths. Writes to address 0 with bit 4 set start the initialization sequence, which then takes its remaining words from address 1. Other writes to address 0 are operation commands. With bit 3 set they control read select, polling and special mask. With bit 3 clear they are end-of-interrupt and priority commands, taken from bits 7 to 5. The end-of-interrupt commands clear in-service bits through a one-cycle `isr_clr_o` pulse. The non-specific forms use a rotating-priority search over the in-service bits that the resolver reports.

Single mode and level triggering are not supported. The level bit is ignored. The single bit only changes how many initialization words are expected.

Top module: `pic_cmd_decoder`

## Requirements
- R1: After reset every configuration output, `rd_data_o`, `isr_clr_o` and `poll_ack_o` are zero, so reads of address 0 select the request register.
- R2: A write to address 0 with bit 4 set starts initialization. On the next cycle `isr_clr_o` is 8'hFF for one cycle. The mask, rotation base, special mask, read select, auto-EOI, rotate-on-auto-EOI and special nested outputs are cleared, and any pending poll is dropped.
- R3: The first address-1 write after that start is the base word. `vec_base_o` takes data bits 7 to 3. The mask is not changed by any initialization word.
- R4: If bit 1 of the start word is 0, one further address-1 word follows the base word and its content is ignored. If bit 1 is 1, that word is skipped. If bit 0 of the start word is 1, a final mode word follows. Otherwise initialization ends, and the next address-1 write loads the mask. Bit 3 of the start word has no effect.
- R5: In the mode word, data bit 4 sets `sfnm_o` and data bit 1 sets `auto_eoi_o`.
- R6: Outside initialization, an address-1 write loads `mask_o`. An address-1 read returns the mask on `rd_data_o` on the following cycle.
- R7: An address-0 write with bit 4 = 0 and bit 3 = 1 is a read/poll command. If bit 1 is 1, bit 0 is copied to `rd_isr_sel_o`. If bit 6 is 1, bit 5 is copied to `smask_o`. When the enabling bit is 0, the output keeps its value.
- R8: With no poll pending, an address-0 read returns `isr_i` when `rd_isr_sel_o`=1 and `irr_i` when it is 0, on the following cycle.
- R9: Bit 2 of a read/poll command sets a pending poll. The next address-0 read returns {poll_hit_i, 4'b0, poll_id_i} and clears the pending poll. `poll_ack_o` pulses for one cycle after that read only if `poll_hit_i` was 1.
- R10: An end-of-interrupt/priority command is an address-0 write with bits 4 and 3 both 0, and its command code is bits 7 to 5. Code 1 clears the in-service bit of highest priority. Priority runs from `rot_base_o` upward, modulo 8. If no bit is in service, nothing is cleared. Code 5 does the same and also sets `rot_base_o` to (cleared number + 1) mod 8.
- R11: Code 3 clears in-service bit data[2:0]. Code 7 clears it and sets `rot_base_o` to (data[2:0] + 1) mod 8. Code 6 only sets `rot_base_o` that way. Code 2 has no effect.
- R12: Codes 0 and 4 set `rot_aeoi_o` to data bit 7.
- R13: `isr_clr_o` is nonzero only on the single cycle after the address-0 write that caused it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_i | input | 1 | Register address (0 or 1) |
| wr_en_i | input | 1 | Write strobe, one cycle per byte |
| rd_en_i | input | 1 | Read strobe, one cycle per byte |
| wr_data_i | input | 8 | Write data |
| irr_i | input | 8 | Request register from the resolver |
| isr_i | input | 8 | In-service register from the resolver |
| poll_hit_i | input | 1 | Resolver has a winning request |
| poll_id_i | input | 3 | Number of the winning request |
| rd_data_o | output | 8 | Registered read data |
| mask_o | output | 8 | Interrupt mask |
| vec_base_o | output | 5 | Vector base (upper five bits) |
| rot_base_o | output | 3 | Input number that currently has the highest priority |
| auto_eoi_o | output | 1 | Auto end-of-interrupt mode |
| rot_aeoi_o | output | 1 | Rotate on auto end-of-interrupt |
| sfnm_o | output | 1 | Special fully nested mode |
| smask_o | output | 1 | Special mask mode |
| rd_isr_sel_o | output | 1 | Address-0 reads return in-service (1) or request (0) |
| isr_clr_o | output | 8 | One-cycle in-service clear pulse |
| poll_ack_o | output | 1 | One-cycle pulse: poll result consumed |

## Verification
The assertions check rules that hold on every cycle. A clear pulse only ever follows an address-0 write, and apart from the full clear at initialization it has at most one bit set. The mask only moves after a write, and the poll acknowledge only follows an address-0 read. The rotating search always returns a bit that is actually in service, and the base word stays fixed outside initialization. Only the bench's scenarios can show the rest. These are the word counts of the initialization sequence in each start-word mode, and which in-service bit each end-of-interrupt code picks for a given rotation base. They also cover the enable bits of the read/poll command that gate their data bits, and the read-back values.

// File: rtl/pic_cmd_pkg.sv
package pic_cmd_pkg;
  typedef enum logic [1:0] {
    INIT_IDLE = 2'd0,
    INIT_BASE = 2'd1,
    INIT_CASC = 2'd2,
    INIT_MODE = 2'd3
  } init_state_t;

  localparam logic [2:0] CMD_AEOI_OFF = 3'd0;
  localparam logic [2:0] CMD_NS_EOI   = 3'd1;
  localparam logic [2:0] CMD_SP_EOI   = 3'd3;
  localparam logic [2:0] CMD_AEOI_ON  = 3'd4;
  localparam logic [2:0] CMD_NS_ROT   = 3'd5;
  localparam logic [2:0] CMD_SET_PRI  = 3'd6;
  localparam logic [2:0] CMD_SP_ROT   = 3'd7;
endpackage

// File: rtl/pic_prio_find.sv
module pic_prio_find #(
  parameter int N  = 8,
  localparam int IW = $clog2(N)
) (
  input  logic [N-1:0]  req_i,
  input  logic [IW-1:0] rot_i,
  output logic          found_o,
  output logic [IW-1:0] idx_o
);
  logic [IW-1:0] pos;

  // Scan from the rotation base upward; N is a power of two so the sum wraps.
  always_comb begin
    found_o = 1'b0;
    idx_o   = '0;
    pos     = '0;
    for (int k = 0; k < N; k++) begin
      pos = rot_i + IW'(k);
      if (!found_o && req_i[pos]) begin
        found_o = 1'b1;
        idx_o   = pos;
      end
    end
  end

  always_comb begin
    if (found_o) assert_found_in_service_R10: assert (req_i[idx_o]);
    if (!found_o) assert_none_means_empty_R10: assert (req_i == '0);
  end
endmodule

// File: rtl/pic_init_seq.sv
module pic_init_seq
  import pic_cmd_pkg::*;
#(
  parameter int BW = 5
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start_i,
  input  logic [7:0]    start_word_i,
  input  logic          dat_wr_i,
  input  logic [7:0]    data_i,
  output logic          busy_o,
  output logic [BW-1:0] base_o,
  output logic          sfnm_o,
  output logic          aeoi_o
);
  init_state_t st;
  logic need4_q, single_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= INIT_IDLE;
      need4_q  <= 1'b0;
      single_q <= 1'b0;
      base_o   <= '0;
      sfnm_o   <= 1'b0;
      aeoi_o   <= 1'b0;
    end else if (start_i) begin
      st       <= INIT_BASE;
      need4_q  <= start_word_i[0];
      single_q <= start_word_i[1];
      base_o   <= '0;
      sfnm_o   <= 1'b0;
      aeoi_o   <= 1'b0;
    end else if (dat_wr_i) begin
      case (st)
        INIT_BASE: begin
          base_o <= data_i[7 -: BW];
          if (!single_q)    st <= INIT_CASC;
          else if (need4_q) st <= INIT_MODE;
          else              st <= INIT_IDLE;
        end
        INIT_CASC: st <= need4_q ? INIT_MODE : INIT_IDLE;
        INIT_MODE: begin
          sfnm_o <= data_i[4];
          aeoi_o <= data_i[1];
          st     <= INIT_IDLE;
        end
        default: st <= INIT_IDLE;
      endcase
    end
  end

  assign busy_o = (st != INIT_IDLE);

  assert_mode_needs_flag_R4: assert property (@(posedge clk) disable iff (rst)
    (st == INIT_MODE) |-> need4_q);
  assert_base_held_idle_R3: assert property (@(posedge clk) disable iff (rst)
    (st == INIT_IDLE && $past(st) == INIT_IDLE && !$past(start_i)) |-> $stable(base_o));
endmodule

// File: rtl/pic_ocw_exec.sv
module pic_ocw_exec
  import pic_cmd_pkg::*;
#(
  parameter int N  = 8,
  localparam int IW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cmd_wr_i,
  input  logic [7:0]    data_i,
  input  logic          init_i,
  input  logic          poll_done_i,
  input  logic [N-1:0]  isr_i,
  output logic [IW-1:0] rot_base_o,
  output logic          rot_aeoi_o,
  output logic          rd_isr_o,
  output logic          smask_o,
  output logic          poll_pend_o,
  output logic [N-1:0]  isr_clr_o
);
  logic          is_rdcmd, is_eoi, top_found;
  logic [IW-1:0] top_idx, lvl;
  logic [2:0]    code;

  assign is_rdcmd = cmd_wr_i && !data_i[4] &&  data_i[3];
  assign is_eoi   = cmd_wr_i && !data_i[4] && !data_i[3];
  assign code     = data_i[7:5];
  assign lvl      = data_i[IW-1:0];

  pic_prio_find #(.N(N)) u_find (
    .req_i   (isr_i),
    .rot_i   (rot_base_o),
    .found_o (top_found),
    .idx_o   (top_idx)
  );

  always_ff @(posedge clk) begin
    if (rst || init_i) begin
      rot_base_o  <= '0;
      rot_aeoi_o  <= 1'b0;
      rd_isr_o    <= 1'b0;
      smask_o     <= 1'b0;
      poll_pend_o <= 1'b0;
      isr_clr_o   <= rst ? '0 : '1;
    end else begin
      isr_clr_o <= '0;
      if (poll_done_i) poll_pend_o <= 1'b0;
      if (is_rdcmd) begin
        if (data_i[2]) poll_pend_o <= 1'b1;
        if (data_i[1]) rd_isr_o    <= data_i[0];
        if (data_i[6]) smask_o     <= data_i[5];
      end
      if (is_eoi) begin
        case (code)
          CMD_AEOI_OFF, CMD_AEOI_ON: rot_aeoi_o <= data_i[7];
          CMD_NS_EOI: if (top_found) isr_clr_o <= N'(1) << top_idx;
          CMD_NS_ROT: if (top_found) begin
            isr_clr_o  <= N'(1) << top_idx;
            rot_base_o <= top_idx + 1'b1;
          end
          CMD_SP_EOI: isr_clr_o <= N'(1) << lvl;
          CMD_SP_ROT: begin
            isr_clr_o  <= N'(1) << lvl;
            rot_base_o <= lvl + 1'b1;
          end
          CMD_SET_PRI: rot_base_o <= lvl + 1'b1;
          default: ;
        endcase
      end
    end
  end

  assert_clr_after_write_R13: assert property (@(posedge clk) disable iff (rst)
    (isr_clr_o != '0) |-> $past(cmd_wr_i));
  assert_clr_single_bit_R11: assert property (@(posedge clk) disable iff (rst)
    (isr_clr_o != '1) |-> $onehot0(isr_clr_o));
endmodule

// File: rtl/pic_cmd_decoder.sv
module pic_cmd_decoder
  import pic_cmd_pkg::*;
#(
  parameter int N  = 8,
  localparam int IW = $clog2(N),
  localparam int BW = 8 - IW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          addr_i,
  input  logic          wr_en_i,
  input  logic          rd_en_i,
  input  logic [7:0]    wr_data_i,
  input  logic [N-1:0]  irr_i,
  input  logic [N-1:0]  isr_i,
  input  logic          poll_hit_i,
  input  logic [IW-1:0] poll_id_i,
  output logic [7:0]    rd_data_o,
  output logic [N-1:0]  mask_o,
  output logic [BW-1:0] vec_base_o,
  output logic [IW-1:0] rot_base_o,
  output logic          auto_eoi_o,
  output logic          rot_aeoi_o,
  output logic          sfnm_o,
  output logic          smask_o,
  output logic          rd_isr_sel_o,
  output logic [N-1:0]  isr_clr_o,
  output logic          poll_ack_o
);
  logic cmd_wr, dat_wr, init_start, busy, poll_pend, poll_done;
  logic [7:0] poll_byte;

  assign cmd_wr     = wr_en_i && !addr_i;
  assign dat_wr     = wr_en_i &&  addr_i;
  assign init_start = cmd_wr && wr_data_i[4];
  assign poll_done  = rd_en_i && !addr_i && poll_pend;
  assign poll_byte  = {poll_hit_i, {(7 - IW){1'b0}}, poll_id_i};

  pic_init_seq #(.BW(BW)) u_init (
    .clk          (clk),
    .rst          (rst),
    .start_i      (init_start),
    .start_word_i (wr_data_i),
    .dat_wr_i     (dat_wr),
    .data_i       (wr_data_i),
    .busy_o       (busy),
    .base_o       (vec_base_o),
    .sfnm_o       (sfnm_o),
    .aeoi_o       (auto_eoi_o)
  );

  pic_ocw_exec #(.N(N)) u_ocw (
    .clk         (clk),
    .rst         (rst),
    .cmd_wr_i    (cmd_wr),
    .data_i      (wr_data_i),
    .init_i      (init_start),
    .poll_done_i (poll_done),
    .isr_i       (isr_i),
    .rot_base_o  (rot_base_o),
    .rot_aeoi_o  (rot_aeoi_o),
    .rd_isr_o    (rd_isr_sel_o),
    .smask_o     (smask_o),
    .poll_pend_o (poll_pend),
    .isr_clr_o   (isr_clr_o)
  );

  always_ff @(posedge clk) begin
    if (rst || init_start) mask_o <= '0;
    else if (dat_wr && !busy) mask_o <= wr_data_i[N-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data_o  <= '0;
      poll_ack_o <= 1'b0;
    end else begin
      poll_ack_o <= poll_done && poll_hit_i;
      if (rd_en_i) begin
        if (addr_i)            rd_data_o <= 8'(mask_o);
        else if (poll_pend)    rd_data_o <= poll_byte;
        else if (rd_isr_sel_o) rd_data_o <= 8'(isr_i);
        else                   rd_data_o <= 8'(irr_i);
      end
    end
  end

  assert_mask_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !$past(wr_en_i) |-> (mask_o == $past(mask_o)));
  assert_poll_ack_after_read_R9: assert property (@(posedge clk) disable iff (rst)
    poll_ack_o |-> $past(rd_en_i && !addr_i));
endmodule

// File: tb/pic_cmd_decoder_test.sv
`timescale 1ns/100ps
module pic_cmd_decoder_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic addr_i = 1'b0, wr_en_i = 1'b0, rd_en_i = 1'b0;
  logic [7:0] wr_data_i = '0, irr_i = '0, isr_i = '0;
  logic poll_hit_i = 1'b0;
  logic [2:0] poll_id_i = '0;
  logic [7:0] rd_data_o, mask_o, isr_clr_o;
  logic [4:0] vec_base_o;
  logic [2:0] rot_base_o;
  logic auto_eoi_o, rot_aeoi_o, sfnm_o, smask_o, rd_isr_sel_o, poll_ack_o;

  int checks = 0, failures = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pic_cmd_decoder uut (.*);

  // pre-command (sets rotation base), isr, command, expected clear, expected rotation base
  localparam int NV = 11;
  localparam logic [34:0] VEC [NV] = '{
    {8'hC7, 8'h0A, 8'h20, 8'h02, 3'd0},
    {8'hC2, 8'h0A, 8'h20, 8'h08, 3'd3},
    {8'hC3, 8'h0A, 8'h20, 8'h02, 3'd4},
    {8'hC7, 8'h00, 8'h20, 8'h00, 3'd0},
    {8'hC7, 8'h90, 8'hA0, 8'h10, 3'd5},
    {8'hC5, 8'h41, 8'hA0, 8'h40, 3'd7},
    {8'hC7, 8'hFF, 8'h65, 8'h20, 3'd0},
    {8'hC7, 8'h00, 8'hE2, 8'h04, 3'd3},
    {8'hC7, 8'hFF, 8'hC4, 8'h00, 3'd5},
    {8'hC7, 8'hFF, 8'h40, 8'h00, 3'd0},
    {8'hC0, 8'h01, 8'hA0, 8'h01, 3'd1}
  };

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(logic a, logic [7:0] d);
    addr_i = a; wr_data_i = d; wr_en_i = 1'b1;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(logic a);
    addr_i = a; rd_en_i = 1'b1;
    @(negedge clk);
    rd_en_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 mask", mask_o, 0);
    chk("R1 base", vec_base_o, 0);
    chk("R1 rot", rot_base_o, 0);
    chk("R1 flags", {auto_eoi_o, rot_aeoi_o, sfnm_o, smask_o, rd_isr_sel_o, poll_ack_o}, 0);
    chk("R1 clr", isr_clr_o, 0);
    chk("R1 rdata", rd_data_o, 0);

    // R6 mask load while idle
    wr(1, 8'h5A);
    chk("R6 mask load", mask_o, 8'h5A);
    wr(0, 8'h0B); // read in-service select, to see it cleared by init
    wr(0, 8'h68); // special mask on
    // R2 start initialization (need mode word, cascade expected)
    wr(0, 8'h11);
    chk("R2 clr all", isr_clr_o, 8'hFF);
    chk("R2 mask cleared", mask_o, 0);
    chk("R2 sel cleared", {smask_o, rd_isr_sel_o}, 0);
    @(negedge clk);
    chk("R13 clr one cycle", isr_clr_o, 0);
    wr(1, 8'h48);
    chk("R3 base", vec_base_o, 5'd9);
    chk("R3 mask untouched", mask_o, 0);
    wr(1, 8'h04);
    chk("R4 cascade word ignored", {mask_o, 3'b0, vec_base_o}, {8'h00, 8'h09});
    wr(1, 8'h12);
    chk("R5 mode word", {sfnm_o, auto_eoi_o}, 2'b11);
    chk("R4 mode word no mask", mask_o, 0);
    wr(1, 8'h3C);
    chk("R6 mask after init", mask_o, 8'h3C);
    rd(1);
    chk("R6 mask read", rd_data_o, 8'h3C);

    // R4 single mode and level bit: base word then idle
    wr(0, 8'h1A);
    chk("R2 mode flags cleared", {sfnm_o, auto_eoi_o}, 0);
    wr(1, 8'h20);
    chk("R3 base single", vec_base_o, 5'd4);
    wr(1, 8'h81);
    chk("R4 single skips cascade", mask_o, 8'h81);

    // R4 cascade, no mode word
    wr(0, 8'h10);
    wr(1, 8'hF8);
    chk("R3 base max", vec_base_o, 5'd31);
    wr(1, 8'h55);
    chk("R4 cascade ignored", mask_o, 0);
    wr(1, 8'h66);
    chk("R4 idle after cascade", mask_o, 8'h66);

    // R7/R8 read select
    isr_i = 8'hA5; irr_i = 8'h3C;
    rd(0);
    chk("R8 read irr default", rd_data_o, 8'h3C);
    wr(0, 8'h0B);
    chk("R7 select isr", rd_isr_sel_o, 1);
    rd(0);
    chk("R8 read isr", rd_data_o, 8'hA5);
    wr(0, 8'h08);
    chk("R7 gated select held", rd_isr_sel_o, 1);
    wr(0, 8'h0A);
    rd(0);
    chk("R8 read irr again", rd_data_o, 8'h3C);
    wr(0, 8'h68);
    chk("R7 smask on", smask_o, 1);
    wr(0, 8'h28);
    chk("R7 gated smask held", smask_o, 1);
    wr(0, 8'h48);
    chk("R7 smask off", smask_o, 0);

    // R9 poll
    poll_hit_i = 1'b1; poll_id_i = 3'd5;
    wr(0, 8'h0C);
    rd(0);
    chk("R9 poll byte", rd_data_o, 8'h85);
    chk("R9 poll ack", poll_ack_o, 1);
    rd(0);
    chk("R9 poll cleared", rd_data_o, 8'h3C);
    chk("R9 no second ack", poll_ack_o, 0);
    poll_hit_i = 1'b0; poll_id_i = 3'd0;
    wr(0, 8'h0C);
    rd(0);
    chk("R9 poll empty", rd_data_o, 8'h00);
    chk("R9 no ack empty", poll_ack_o, 0);

    // R12 rotate on auto-EOI
    wr(0, 8'h80);
    chk("R12 set", rot_aeoi_o, 1);
    wr(0, 8'h40);
    chk("R11 code2 no effect", {rot_aeoi_o, isr_clr_o}, {1'b1, 8'h00});
    wr(0, 8'h00);
    chk("R12 clear", rot_aeoi_o, 0);

    // R10/R11 end-of-interrupt table
    for (int i = 0; i < NV; i++) begin
      isr_i = VEC[i][26:19];
      wr(0, VEC[i][34:27]);
      wr(0, VEC[i][18:11]);
      chk($sformatf("R10 R11 vec%0d clr", i), isr_clr_o, VEC[i][10:3]);
      chk($sformatf("R10 R11 vec%0d rot", i), rot_base_o, VEC[i][2:0]);
    end
    @(negedge clk);
    chk("R13 pulse ends", isr_clr_o, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule